// File: doc/BRIEF.md
# Receive Descriptor Ring Chaining Engine

This engine places one received Ethernet frame into host memory through a ring of receive descriptors. A frame is announced by a one-cycle start pulse that carries its byte count and its destination address. The frame bytes then arrive on a byte stream with a valid/ready handshake. The engine decides whether the frame is wanted. For a wanted frame it walks the ring from its current position and fills one host buffer after another. Each descriptor is returned to the host as the engine finishes with it. The descriptor that opened the frame is returned last. A one-cycle receive-interrupt event follows that final write.

All host traffic goes through one word-wide memory master port. Only one access is outstanding at a time, and each access is held until it is acknowledged. Frame data is packed into 32-bit words, least significant byte first. Descriptor status and count words are read, modified and written back as whole words. Bytes the engine does not store are still taken from the stream and thrown away, so the stream never stalls. This covers rejected frames, the part of an oversized frame beyond the limit, and the rest of a frame that ran out of buffers.

Top module: `rxr_chain_engine`

## Requirements
- R1: Descriptor k sits at ring base + 16·k. The ring position advances by one after every buffer is filled and wraps to 0 when it reaches the ring length.
- R2: With style 2 the buffer address is at descriptor byte offset 0 and the count word at offset 8. With style 3 these two words trade places. The status word is at offset 4 in both styles. Any other style value drops the frame with no memory access.
- R3: A frame is wanted when promiscuous is set, or when bit 0 of the first destination byte (frm_dest[7:0]) is 1, or when all 48 destination bits equal the station address. An unwanted frame makes no memory access.
- R4: When the ring base is zero or the receiver enable is low, the frame makes no memory access and raises no event.
- R5: If the status word at the current position has bit 31 (device owns) clear, the frame is dropped without any memory write, and the ring position does not move.
- R6: The usable size of a buffer is the negation of status bits 11:0, modulo 4096. Each buffer takes the smaller of that size and the bytes still to store. Bytes are packed little-endian, and a short last word writes only byte lanes 0..n-1 (byte enable bit i = lane i).
- R7: Only the first 2048 bytes of a longer frame are stored. The remainder is consumed and discarded.
- R8: Every descriptor other than the first gets bit 31 cleared when released. The descriptor holding the last byte gets bit 24 (end). Its count word gets bits 11:0 = stored length + 4, with bits 31:12 kept.
- R9: If the next descriptor is not owned while bytes remain, the current one gets bits 30, 27 and 24 set, and storing stops. The ring position is left on the unowned descriptor.
- R10: The first descriptor's status is written last, with bit 31 cleared, bit 25 (start) set and its other bits kept. The next cycle carries a single-cycle rx_irq pulse.
- R11: busy rises after a start pulse and stays high until the frame has been fully handled and its bytes consumed. A start pulse while busy is ignored. in_ready is never high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | 32 | Byte address of descriptor 0 |
| cfg_ring_len | input | 10 | Number of descriptors in the ring |
| cfg_station | input | 48 | Station address, first wire byte in bits 7:0 |
| cfg_promisc | input | 1 | Accept every destination |
| cfg_rx_on | input | 1 | Receiver enable |
| cfg_style | input | 8 | Descriptor word layout selector (2 or 3) |
| frm_start | input | 1 | Start-of-frame pulse |
| frm_len | input | 12 | Frame byte count, valid with frm_start |
| frm_dest | input | 48 | Destination address, valid with frm_start |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Byte taken when high with in_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| busy | output | 1 | Frame in progress |
| rx_irq | output | 1 | Receive-complete event pulse |

## Verification
Frames of several lengths are tried against several buffer sizes. This separates a frame that fits one buffer, an exact multiple of the buffer size, a length that leaves a short word in each buffer, a chain that spans all four descriptors, and a 2100-byte frame that must be cut to 2048. The destination is varied over exact match, multicast, promiscuous foreign, and foreign without promiscuous, which shows each acceptance path separately. Both word layouts are used, so swapped address and count words show up as misplaced data. Ring runs that start at varying positions and wrap past the end expose position errors, because the next frame then lands in the wrong descriptor. Directed cases then cover an unowned first descriptor, an unowned successor, a zero base, a disabled receiver, an invalid style, and a stray start pulse during a frame.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
    localparam int B_OWN = 31;
    localparam int B_ERR = 30;
    localparam int B_BUFF = 27;
    localparam int B_STP = 25;
    localparam int B_ENP = 24;
    localparam int SZ_W = 12;
    localparam int DESC_BYTES = 16;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_ST, S_RD_BA, S_FILL, S_WR_DAT, S_ADV, S_RD_NX,
        S_WR_ST, S_RD_CNT, S_WR_CNT, S_WR_FST, S_DRAIN
    } st_e;
endpackage

// File: rtl/rxr_dest_filter.sv
`timescale 1ns/1ps
module rxr_dest_filter #(
    parameter int NBYTES = 6
) (
    input  logic [8*NBYTES-1:0] dest,
    input  logic [8*NBYTES-1:0] station,
    input  logic                promisc,
    output logic                hit
);
    logic [NBYTES-1:0] same;
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign same[i] = (dest[8*i +: 8] == station[8*i +: 8]);
    end
    // group bit is the lowest bit of the first byte on the wire
    assign hit = promisc | dest[0] | (&same);
endmodule

// File: rtl/rxr_ring_step.sv
`timescale 1ns/1ps
module rxr_ring_step #(
    parameter int AW = 32,
    parameter int POS_W = 9,
    parameter int DESC_B = 16
) (
    input  logic [AW-1:0]    base,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W:0]   len,
    output logic [AW-1:0]    addr,
    output logic [POS_W-1:0] nxt
);
    localparam int SH = $clog2(DESC_B);
    logic [POS_W:0] inc;
    assign addr = base + (AW'(pos) << SH);
    assign inc  = {1'b0, pos} + {{POS_W{1'b0}}, 1'b1};
    assign nxt  = (inc == len) ? '0 : inc[POS_W-1:0];
endmodule

// File: rtl/rxr_chain_engine.sv
`timescale 1ns/1ps
module rxr_chain_engine
    import rxr_pkg::*;
#(
    parameter int AW = 32,
    parameter int POS_W = 9,
    parameter int LEN_W = 12,
    parameter int MAX_FRAME = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cfg_ring_base,
    input  logic [POS_W:0]   cfg_ring_len,
    input  logic [47:0]      cfg_station,
    input  logic             cfg_promisc,
    input  logic             cfg_rx_on,
    input  logic [7:0]       cfg_style,
    input  logic             frm_start,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [47:0]      frm_dest,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_be,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             busy,
    output logic             rx_irq
);
    localparam logic [31:0] M_OWN = 32'h1 << B_OWN;
    localparam logic [31:0] M_ERRB = (32'h1 << B_ERR) | (32'h1 << B_BUFF) | (32'h1 << B_ENP);
    localparam logic [31:0] M_ENP = 32'h1 << B_ENP;
    localparam logic [31:0] M_STP = 32'h1 << B_STP;
    localparam logic [LEN_W-1:0] LIM = LEN_W'(MAX_FRAME);

    typedef struct packed {
        st_e              st;
        st_e              ret;
        logic [POS_W-1:0] pos;
        logic [AW-1:0]    cur;
        logic [AW-1:0]    fst;
        logic [AW-1:0]    bptr;
        logic [31:0]      st0;
        logic [31:0]      stc;
        logic [31:0]      nst;
        logic [31:0]      word;
        logic             first;
        logic             sty3;
        logic [LEN_W-1:0] chunk;
        logic [LEN_W-1:0] rem;
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] tot;
        logic [2:0]       nb;
        logic             irq;
    } regs_t;

    regs_t q_q, q_d;
    logic [AW-1:0]    pos_addr;
    logic [POS_W-1:0] pos_nxt;
    logic             hit;
    logic             go;
    logic [SZ_W-1:0]  bneg;
    logic [LEN_W-1:0] bsize;
    logic [31:0]      s;

    rxr_ring_step #(.AW(AW), .POS_W(POS_W), .DESC_B(DESC_BYTES)) u_step (
        .base(cfg_ring_base), .pos(q_q.pos), .len(cfg_ring_len),
        .addr(pos_addr), .nxt(pos_nxt)
    );

    rxr_dest_filter #(.NBYTES(6)) u_filt (
        .dest(frm_dest), .station(cfg_station), .promisc(cfg_promisc), .hit(hit)
    );

    assign go    = (|cfg_ring_base) && cfg_rx_on && (cfg_style == 8'd2 || cfg_style == 8'd3) && hit;
    assign bneg  = {SZ_W{1'b0}} - q_q.stc[SZ_W-1:0];
    assign bsize = LEN_W'(bneg);

    always_comb begin
        q_d = q_q;
        q_d.irq = 1'b0;
        s = q_q.stc;
        case (q_q.st)
            S_IDLE: if (frm_start) begin
                q_d.left  = frm_len;
                q_d.tot   = (frm_len > LIM) ? LIM : frm_len;
                q_d.rem   = (frm_len > LIM) ? LIM : frm_len;
                q_d.cur   = pos_addr;
                q_d.fst   = pos_addr;
                q_d.first = 1'b1;
                q_d.sty3  = (cfg_style == 8'd3);
                q_d.st    = go ? S_RD_ST : S_DRAIN;
            end
            S_RD_ST: if (mem_ack) begin
                if (!mem_rdata[B_OWN]) q_d.st = S_DRAIN;
                else begin
                    q_d.st0 = mem_rdata;
                    q_d.stc = mem_rdata;
                    q_d.st  = S_RD_BA;
                end
            end
            S_RD_BA: if (mem_ack) begin
                q_d.bptr  = mem_rdata;
                q_d.chunk = (bsize < q_q.rem) ? bsize : q_q.rem;
                q_d.nb    = 3'd0;
                q_d.word  = '0;
                q_d.st    = S_FILL;
            end
            S_FILL: begin
                if (q_q.nb == 3'd4 || (q_q.chunk == '0 && q_q.nb != 3'd0)) q_d.st = S_WR_DAT;
                else if (q_q.chunk == '0) q_d.st = S_ADV;
                else if (in_valid) begin
                    q_d.word[{q_q.nb[1:0], 3'b000} +: 8] = in_data;
                    q_d.nb    = q_q.nb + 3'd1;
                    q_d.chunk = q_q.chunk - LEN_W'(1);
                    q_d.rem   = q_q.rem - LEN_W'(1);
                    q_d.left  = q_q.left - LEN_W'(1);
                end
            end
            S_WR_DAT: if (mem_ack) begin
                q_d.bptr = q_q.bptr + AW'(4);
                q_d.nb   = 3'd0;
                q_d.word = '0;
                q_d.st   = S_FILL;
            end
            S_ADV: begin
                q_d.pos = pos_nxt;
                if (q_q.rem == '0) begin
                    s = q_q.stc | M_ENP;
                    if (!q_q.first) s = s & ~M_OWN;
                    q_d.stc = s;
                    if (q_q.first) q_d.st0 = s;
                    q_d.st = S_RD_CNT;
                end else q_d.st = S_RD_NX;
            end
            S_RD_NX: if (mem_ack) begin
                if (!mem_rdata[B_OWN]) begin
                    s = q_q.stc | M_ERRB;
                    if (!q_q.first) s = s & ~M_OWN;
                    q_d.stc = s;
                    if (q_q.first) q_d.st0 = s;
                    q_d.ret = S_WR_FST;
                    q_d.st  = q_q.first ? S_WR_FST : S_WR_ST;
                end else if (q_q.first) begin
                    q_d.first = 1'b0;
                    q_d.cur   = pos_addr;
                    q_d.stc   = mem_rdata;
                    q_d.st    = S_RD_BA;
                end else begin
                    q_d.nst = mem_rdata;
                    q_d.stc = q_q.stc & ~M_OWN;
                    q_d.ret = S_RD_BA;
                    q_d.st  = S_WR_ST;
                end
            end
            S_WR_ST: if (mem_ack) begin
                if (q_q.ret == S_RD_BA) begin
                    q_d.cur = pos_addr;
                    q_d.stc = q_q.nst;
                end
                q_d.st = q_q.ret;
            end
            S_RD_CNT: if (mem_ack) begin
                q_d.word = mem_rdata;
                q_d.st   = S_WR_CNT;
            end
            S_WR_CNT: if (mem_ack) begin
                q_d.ret = S_WR_FST;
                q_d.st  = q_q.first ? S_WR_FST : S_WR_ST;
            end
            S_WR_FST: if (mem_ack) begin
                q_d.irq = 1'b1;
                q_d.st  = (q_q.left != '0) ? S_DRAIN : S_IDLE;
            end
            S_DRAIN: begin
                if (q_q.left == '0) q_d.st = S_IDLE;
                else if (in_valid) q_d.left = q_q.left - LEN_W'(1);
            end
            default: q_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = q_q.cur + AW'(4);
        mem_wdata = q_q.stc;
        mem_be    = 4'hF;
        case (q_q.st)
            S_RD_ST:  ;
            S_RD_BA:  mem_addr = q_q.cur + (q_q.sty3 ? AW'(8) : AW'(0));
            S_WR_DAT: begin
                mem_we    = 1'b1;
                mem_addr  = q_q.bptr;
                mem_wdata = q_q.word;
                mem_be    = 4'((5'd1 << q_q.nb) - 5'd1);
            end
            S_RD_NX:  mem_addr = pos_addr + AW'(4);
            S_WR_ST:  mem_we = 1'b1;
            S_RD_CNT: mem_addr = q_q.cur + (q_q.sty3 ? AW'(0) : AW'(8));
            S_WR_CNT: begin
                mem_we    = 1'b1;
                mem_addr  = q_q.cur + (q_q.sty3 ? AW'(0) : AW'(8));
                mem_wdata = {q_q.word[31:SZ_W], SZ_W'(q_q.tot) + SZ_W'(4)};
            end
            S_WR_FST: begin
                mem_we    = 1'b1;
                mem_addr  = q_q.fst + AW'(4);
                mem_wdata = (q_q.st0 & ~M_OWN) | M_STP;
            end
            default:  mem_req = 1'b0;
        endcase
    end

    assign in_ready = (q_q.st == S_FILL && q_q.chunk != '0 && q_q.nb != 3'd4) ||
                      (q_q.st == S_DRAIN && q_q.left != '0);
    assign busy     = (q_q.st != S_IDLE);
    assign rx_irq   = q_q.irq;

    // R1: an access stays presented, unchanged, until acknowledged
    a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    a_r6_lane_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !in_ready);
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    a_r10_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(mem_req && mem_we && mem_ack));
endmodule

// File: tb/sim_rxr_chain_engine.sv
`timescale 1ns/1ps
module sim_rxr_chain_engine;
    localparam int RING = 32'h100;
    localparam int BUF0 = 32'h1000;
    localparam logic [31:0] CNT_INIT = 32'hABCD_E000;
    localparam logic [47:0] STATION = 48'h5544_3322_1100;
    localparam logic [47:0] MCAST   = 48'h0000_0000_5E01;
    localparam logic [47:0] OTHER   = 48'h5444_3322_1100;

    typedef struct packed {
        logic [11:0] len;
        logic [11:0] bsz;
        logic [1:0]  mode;
        logic        sty3;
        logic [2:0]  nown;
        logic        dbl;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{12'd10,   12'd16,   2'd0, 1'b0, 3'd4, 1'b0},
        '{12'd40,   12'd16,   2'd1, 1'b0, 3'd4, 1'b0},
        '{12'd32,   12'd16,   2'd2, 1'b1, 3'd4, 1'b0},
        '{12'd50,   12'd18,   2'd0, 1'b1, 3'd4, 1'b1},
        '{12'd61,   12'd20,   2'd3, 1'b0, 3'd4, 1'b0},
        '{12'd3,    12'd64,   2'd1, 1'b0, 3'd4, 1'b0},
        '{12'd48,   12'd16,   2'd0, 1'b0, 3'd2, 1'b0},
        '{12'd2100, 12'd2048, 2'd0, 1'b0, 3'd4, 1'b0},
        '{12'd7,    12'd4,    2'd0, 1'b1, 3'd4, 1'b0},
        '{12'd64,   12'd16,   2'd0, 1'b0, 3'd4, 1'b0}
    };

    logic clk = 0, rst_n = 0;
    logic [31:0] cfg_ring_base = RING;
    logic [9:0]  cfg_ring_len = 10'd4;
    logic [47:0] cfg_station = STATION;
    logic        cfg_promisc = 0, cfg_rx_on = 1;
    logic [7:0]  cfg_style = 8'd2;
    logic        frm_start = 0;
    logic [11:0] frm_len = 0;
    logic [47:0] frm_dest = 0;
    logic        in_valid = 0;
    logic [7:0]  in_data = 0;
    logic        in_ready, mem_req, mem_we, mem_ack, busy, rx_irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;

    logic [31:0] mem [0:4095];
    int acc_cnt = 0, wr_cnt = 0, irq_cnt = 0, cyc = 0;
    int n_chk = 0, n_fail = 0, bp = 0;

    always #10 clk = ~clk;

    rxr_chain_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_ring_len(cfg_ring_len),
        .cfg_station(cfg_station), .cfg_promisc(cfg_promisc), .cfg_rx_on(cfg_rx_on),
        .cfg_style(cfg_style), .frm_start(frm_start), .frm_len(frm_len), .frm_dest(frm_dest),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .rx_irq(rx_irq)
    );

    assign mem_rdata = mem[mem_addr[13:2]];

    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack) begin
                acc_cnt <= acc_cnt + 1;
                if (mem_we) begin
                    wr_cnt <= wr_cnt + 1;
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                end
            end
        end
        if (rx_irq) irq_cnt <= irq_cnt + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            $display("FAIL watchdog (all requirements): act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

    function automatic logic [7:0] pat(int k, int seed);
        return 8'(k * 13 + seed * 29 + 5);
    endfunction

    function automatic logic [7:0] mbyte(int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    function automatic logic [31:0] orig_st(int sz, bit own);
        return (own ? 32'h8000_0000 : 32'h0) | (32'(-sz) & 32'hFFF);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic prep(int sz, int nown, bit sty3);
        for (int i = 0; i < 4; i++) begin
            int a = RING + 16 * i;
            bit own = ((i - bp + 4) % 4) < nown;
            mem[a >> 2]       = sty3 ? CNT_INIT : BUF0 + i * 32'h800;
            mem[(a + 4) >> 2] = orig_st(sz, own);
            mem[(a + 8) >> 2] = sty3 ? BUF0 + i * 32'h800 : CNT_INIT;
            mem[(a + 12) >> 2] = 32'h1234_0000 + i;
        end
        for (int w = BUF0 / 4; w < BUF0 / 4 + 2048; w++) mem[w] = 32'h0;
    endtask

    task automatic send(int len, logic [47:0] dst, int seed, bit dbl);
        int k = 0;
        bit rdy;
        @(negedge clk);
        frm_start = 1; frm_len = 12'(len); frm_dest = dst;
        @(negedge clk);
        frm_start = 0;
        chk("R11 busy after start", 32'(busy), 32'd1);
        in_valid = 1;
        while (k < len) begin
            in_data = pat(k, seed);
            frm_start = dbl && (k == 2);
            frm_len = 12'd5;
            #1 rdy = in_ready;
            @(negedge clk);
            if (rdy) k++;
        end
        frm_start = 0; in_valid = 0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // kind 0: stored, 1: no access at all, 2: reads only
    task automatic run(int len, int sz, int mode, bit sty3, int nown, bit dbl, int seed, int kind);
        logic [47:0] dst;
        int a0, w0, i0, lt, n, used, ca;
        bit err;
        dst = (mode == 0) ? STATION : (mode == 1) ? MCAST : OTHER;
        cfg_promisc = (mode == 2);
        if (kind == 0 || kind == 2) cfg_style = sty3 ? 8'd3 : 8'd2;
        prep(sz, nown, sty3);
        a0 = acc_cnt; w0 = wr_cnt; i0 = irq_cnt;
        send(len, dst, seed, dbl);
        if (kind == 1 || mode == 3) begin
            chk(mode == 3 ? "R3 no access" : "R2/R4 no access", 32'(acc_cnt - a0), 32'd0);
            chk("R4 no event", 32'(irq_cnt - i0), 32'd0);
            return;
        end
        if (kind == 2) begin
            chk("R5 no writes", 32'(wr_cnt - w0), 32'd0);
            chk("R5 status kept", mem[(RING + 16 * bp + 4) >> 2], orig_st(sz, 0));
            return;
        end
        lt = (len > 2048) ? 2048 : len;
        n = (lt == 0) ? 1 : (lt + sz - 1) / sz;
        err = n > nown;
        used = err ? nown : n;
        for (int j = 0; j < used; j++) begin
            int idx = (bp + j) % 4;
            int da = RING + 16 * idx;
            int ba = BUF0 + idx * 32'h800;
            int off = j * sz;
            int cl = (lt - off < sz) ? lt - off : sz;
            int bad = 0;
            logic [31:0] e = orig_st(sz, 1) & ~32'h8000_0000;
            if (j == 0) e |= 32'h0200_0000;
            if (j == used - 1) begin
                e |= 32'h0100_0000;
                if (err) e |= 32'h4800_0000;
            end
            chk(j == 0 ? "R10 first status" : (err && j == used - 1) ? "R9 status" : "R1/R8 status",
                mem[(da + 4) >> 2], e);
            if (err && j == used - 1) cl = sz;
            for (int b = 0; b < cl; b++) if (mbyte(ba + b) !== pat(off + b, seed)) bad++;
            if (cl % 4 != 0 && mbyte(ba + cl) !== 8'h00) bad++;
            chk(sty3 ? "R2/R6 data" : "R6 data", 32'(bad), 32'd0);
        end
        ca = RING + 16 * ((bp + used - 1) % 4) + (sty3 ? 0 : 8);
        chk(len > 2048 ? "R7 count" : (err ? "R9 count kept" : "R8 count"),
            mem[ca >> 2], err ? CNT_INIT : CNT_INIT | 32'(lt + 4));
        if (err) chk("R9 unowned kept", mem[(RING + 16 * ((bp + used) % 4) + 4) >> 2], orig_st(sz, 0));
        chk("R10 one event", 32'(irq_cnt - i0), 32'd1);
        bp = (bp + used) % 4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset busy", 32'(busy), 32'd0);
        chk("R11 reset ready", 32'(in_ready), 32'd0);
        chk("R10 reset event", 32'(rx_irq), 32'd0);
        chk("R1 reset req", 32'(mem_req), 32'd0);
        rst_n = 1;
        @(negedge clk);
        for (int v = 0; v < 10; v++)
            run(int'(VEC[v].len), int'(VEC[v].bsz), int'(VEC[v].mode), VEC[v].sty3,
                int'(VEC[v].nown), VEC[v].dbl, v, 0);
        cfg_ring_base = 32'h0;
        run(20, 16, 0, 0, 4, 0, 11, 1);
        cfg_ring_base = RING; cfg_rx_on = 0;
        run(20, 16, 0, 0, 4, 0, 12, 1);
        cfg_rx_on = 1; cfg_style = 8'd5;
        run(20, 16, 0, 0, 4, 0, 13, 1);
        run(20, 16, 1, 0, 0, 0, 14, 2);
        run(20, 16, 0, 1, 4, 0, 15, 0);
        chk("R11 idle ready", 32'(in_ready), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule